// File: doc/BRIEF.md
# Peripheral Port Region Router

This block sits between a core's load/store path and its outgoing buses. Each memory access is compared against two address windows fixed when the chip is integrated: one belonging to an AXI-style peripheral port and one belonging to an AHB-style peripheral port. An access that lands in an enabled window is sent to that window's port. Every other access goes to the default memory port. The decision is registered, so the routed access appears one cycle after it is presented.

A smaller window lies wholly inside the AXI window. Software can switch on separate handling for it. When that handling is on, accesses to the small window still leave on the AXI port. They carry a different transaction ID, so downstream logic may reorder them freely against other AXI traffic. Ordinary AXI-window accesses all share one ID and therefore stay in order among themselves.

The AXI and AHB windows each take their enable from a strap input that is sampled during reset. The inner window has no strap. A software write to a small control register can later set or clear all three enables.

Top module: `pp_router`

## Requirements
- R1: While reset is held and after it is released, the AXI enable equals `strap_axi_en`, the AHB enable equals `strap_ahb_en`, and inner-window handling is off. During reset `rsp_valid` is 0.
- R2: A write with `cfg_we` high replaces all three enables at once: `cfg_wdata[0]` is the AXI enable, `cfg_wdata[1]` is the AHB enable and `cfg_wdata[2]` is the inner-window enable. An access in the same cycle as the write is routed with the old enables. Accesses in later cycles use the new ones.
- R3: Each cycle with `req_valid` high produces exactly one cycle with `rsp_valid` high, in the next cycle. That response carries the same `rsp_addr` and `rsp_write` as the request. Idle cycles produce no response.
- R4: When the AXI window is enabled, an access inside it (and outside the inner window, or with the inner window disabled) gets `rsp_port`=1, `rsp_virt`=0 and `rsp_id`=`ID_AXI`.
- R5: When the AHB window is enabled, an access inside it gets `rsp_port`=2, `rsp_virt`=0 and `rsp_id`=0.
- R6: An access that matches no window, or whose window is disabled, gets `rsp_port`=0, `rsp_virt`=0 and `rsp_id`=0.
- R7: When both the AXI window and inner-window handling are enabled, an access inside the inner window gets `rsp_port`=1, `rsp_virt`=1 and `rsp_id`=`ID_VIRT`. `ID_VIRT` differs from `ID_AXI`.
- R8: When the AXI window is enabled and inner-window handling is off, an inner-window access is routed as ordinary AXI traffic, exactly as in R4.
- R9: When inner-window handling is on but the AXI window is disabled, an inner-window access goes to port 0, as in R6.
- R10: Each window starts at its base address inclusive and ends at base+size exclusive. The first and last byte addresses route into the window. The addresses just outside it do not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_axi_en | input | 1 | Reset-time enable for the AXI peripheral window |
| strap_ahb_en | input | 1 | Reset-time enable for the AHB peripheral window |
| cfg_we | input | 1 | Software write strobe for the enable register |
| cfg_wdata | input | 3 | New enables: bit0 AXI, bit1 AHB, bit2 inner window |
| req_valid | input | 1 | Access present |
| req_addr | input | ADDR_W | Access byte address |
| req_write | input | 1 | Access is a write |
| rsp_valid | output | 1 | Routed access present |
| rsp_port | output | 2 | 0 memory, 1 AXI peripheral, 2 AHB peripheral |
| rsp_virt | output | 1 | Access uses inner-window ordering and ID |
| rsp_id | output | ID_W | Transaction ID for the chosen port |
| rsp_addr | output | ADDR_W | Address passed through |
| rsp_write | output | 1 | Write flag passed through |

## Verification
A software write to the enable register and an access can fall in the same cycle. The key question is which enable set that access sees. The bench drives a control write and a request on the same edge in three situations: turning the AXI window off, turning inner-window handling on, and turning the AHB window on. It then sends the same address again on the next cycle. The scoreboard expects the first access to be routed with the old enables and the second with the new ones.

// File: rtl/pp_router_pkg.sv
package pp_router_pkg;

    typedef enum logic [1:0] {
        PORT_MEM = 2'd0,
        PORT_AXI = 2'd1,
        PORT_AHB = 2'd2
    } pp_port_e;

    typedef struct packed {
        logic virt;
        logic ahb;
        logic axi;
    } pp_en_t;

endpackage

// File: rtl/pp_window_match.sv
module pp_window_match #(
    parameter int          ADDR_W = 32,
    parameter logic [31:0] BASE   = 32'h0,
    parameter logic [31:0] SIZE   = 32'h1000
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam logic [ADDR_W:0] LO = {1'b0, BASE[ADDR_W-1:0]};
    localparam logic [ADDR_W:0] HI = {1'b0, BASE[ADDR_W-1:0]} + {1'b0, SIZE[ADDR_W-1:0]};

    logic [ADDR_W:0] addr_x;

    always_comb begin
        addr_x = {1'b0, addr};
        hit    = (addr_x >= LO) && (addr_x < HI);
    end
endmodule

// File: rtl/pp_enable_reg.sv
module pp_enable_reg
    import pp_router_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   strap_axi_en,
    input  logic   strap_ahb_en,
    input  logic   cfg_we,
    input  logic [2:0] cfg_wdata,
    output pp_en_t en
);
    pp_en_t en_d, en_q;

    always_comb begin
        en_d = en_q;
        if (cfg_we) begin
            en_d.axi  = cfg_wdata[0];
            en_d.ahb  = cfg_wdata[1];
            en_d.virt = cfg_wdata[2];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q.axi  <= strap_axi_en;
            en_q.ahb  <= strap_ahb_en;
            en_q.virt <= 1'b0;
        end else begin
            en_q <= en_d;
        end
    end

    assign en = en_q;

    // R2
    hold_without_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(en_q));
endmodule

// File: rtl/pp_router.sv
module pp_router
    import pp_router_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter int          ID_W      = 4,
    parameter logic [31:0] AXI_BASE  = 32'h4000_0000,
    parameter logic [31:0] AXI_SIZE  = 32'h0100_0000,
    parameter logic [31:0] VIRT_BASE = 32'h4080_0000,
    parameter logic [31:0] VIRT_SIZE = 32'h0010_0000,
    parameter logic [31:0] AHB_BASE  = 32'h5000_0000,
    parameter logic [31:0] AHB_SIZE  = 32'h0100_0000,
    parameter int          ID_AXI    = 1,
    parameter int          ID_VIRT   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_axi_en,
    input  logic              strap_ahb_en,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_wdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    output logic              rsp_valid,
    output logic [1:0]        rsp_port,
    output logic              rsp_virt,
    output logic [ID_W-1:0]   rsp_id,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic              rsp_write
);
    localparam logic [ID_W-1:0] ID_A = ID_W'(ID_AXI);
    localparam logic [ID_W-1:0] ID_V = ID_W'(ID_VIRT);
    localparam int              NWIN = 3;
    localparam logic [NWIN*32-1:0] BASES = {AHB_BASE, VIRT_BASE, AXI_BASE};
    localparam logic [NWIN*32-1:0] SIZES = {AHB_SIZE, VIRT_SIZE, AXI_SIZE};

    typedef struct packed {
        logic              valid;
        pp_port_e          port;
        logic              virt;
        logic [ID_W-1:0]   id;
        logic [ADDR_W-1:0] addr;
        logic              write;
    } out_t;

    pp_en_t          en;
    logic [NWIN-1:0] hit;   // 0 AXI, 1 inner, 2 AHB
    out_t            st_d, st_q;

    pp_enable_reg u_en (
        .clk          (clk),
        .rst_n        (rst_n),
        .strap_axi_en (strap_axi_en),
        .strap_ahb_en (strap_ahb_en),
        .cfg_we       (cfg_we),
        .cfg_wdata    (cfg_wdata),
        .en           (en)
    );

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        pp_window_match #(
            .ADDR_W (ADDR_W),
            .BASE   (BASES[w*32 +: 32]),
            .SIZE   (SIZES[w*32 +: 32])
        ) u_match (
            .addr (req_addr),
            .hit  (hit[w])
        );
    end

    always_comb begin
        st_d       = '0;
        st_d.valid = req_valid;
        st_d.addr  = req_addr;
        st_d.write = req_write;
        st_d.port  = PORT_MEM;
        if (req_valid) begin
            if (hit[0] && en.axi) begin
                st_d.port = PORT_AXI;
                if (hit[1] && en.virt) begin
                    st_d.virt = 1'b1;
                    st_d.id   = ID_V;
                end else begin
                    st_d.id   = ID_A;
                end
            end else if (hit[2] && en.ahb) begin
                st_d.port = PORT_AHB;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.valid;
    assign rsp_port  = st_q.port;
    assign rsp_virt  = st_q.virt;
    assign rsp_id    = st_q.id;
    assign rsp_addr  = st_q.addr;
    assign rsp_write = st_q.write;

    // R1
    reset_idle_chk: assert property (@(posedge clk) !rst_n |-> !rsp_valid);
    // R3
    one_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid && rsp_addr == $past(req_addr));
    // R3
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R7
    virt_on_axi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_virt |-> rsp_port == PORT_AXI && rsp_id == ID_V);
    // R4
    axi_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_port == PORT_AXI && !rsp_virt |-> rsp_id == ID_A);
    // R6
    all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !en.axi && !en.ahb |=> rsp_port == PORT_MEM && rsp_id == '0);
endmodule

// File: tb/pp_router_bench.sv
module pp_router_bench;
    localparam int ADDR_W = 32;
    localparam int ID_W   = 4;

    typedef struct {
        int          due;
        logic [1:0]  port;
        logic        virt;
        logic [3:0]  id;
        logic [31:0] addr;
        logic        write;
        string       req;
    } exp_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic strap_axi_en = 1'b0, strap_ahb_en = 1'b0;
    logic cfg_we = 1'b0;
    logic [2:0] cfg_wdata = '0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic rsp_valid, rsp_virt, rsp_write;
    logic [1:0] rsp_port;
    logic [ID_W-1:0] rsp_id;
    logic [ADDR_W-1:0] rsp_addr;

    int total = 0, bad = 0, cyc = 0;
    logic m_axi = 0, m_ahb = 0, m_virt = 0;
    exp_t q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pp_router u_pp_router (
        .clk(clk), .rst_n(rst_n), .strap_axi_en(strap_axi_en), .strap_ahb_en(strap_ahb_en),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .rsp_valid(rsp_valid), .rsp_port(rsp_port), .rsp_virt(rsp_virt),
        .rsp_id(rsp_id), .rsp_addr(rsp_addr), .rsp_write(rsp_write)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    // drive one cycle at the falling edge; optional access and optional control write
    task automatic step(input bit acc, input logic [31:0] a, input bit w,
                        input bit we, input logic [2:0] wd, input string req);
        exp_t e;
        bit in_axi, in_v, in_ahb;
        @(negedge clk);
        req_valid = acc; req_addr = a; req_write = w;
        cfg_we = we; cfg_wdata = wd;
        if (acc) begin
            in_axi = a >= 32'h4000_0000 && a <= 32'h40FF_FFFF;
            in_v   = a >= 32'h4080_0000 && a <= 32'h408F_FFFF;
            in_ahb = a >= 32'h5000_0000 && a <= 32'h50FF_FFFF;
            e.due = cyc + 1; e.addr = a; e.write = w; e.req = req;
            e.port = 2'd0; e.virt = 1'b0; e.id = 4'd0;
            if (in_axi && m_axi) begin
                e.port = 2'd1;
                if (in_v && m_virt) begin e.virt = 1'b1; e.id = 4'd2; end
                else e.id = 4'd1;
            end else if (in_ahb && m_ahb) e.port = 2'd2;
            q.push_back(e);
        end
        if (we) begin m_axi = wd[0]; m_ahb = wd[1]; m_virt = wd[2]; end
    endtask

    task automatic acc(input logic [31:0] a, input string req);
        step(1'b1, a, a[2], 1'b0, 3'b000, req);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 32'h0, 1'b0, 1'b0, 3'b000, "R3");
    endtask

    task automatic do_reset(input bit sx, input bit sh);
        @(negedge clk);
        rst_n = 1'b0; strap_axi_en = sx; strap_ahb_en = sh;
        req_valid = 1'b0; cfg_we = 1'b0;
        q.delete();
        m_axi = sx; m_ahb = sh; m_virt = 1'b0;
        repeat (2) @(negedge clk);
        check(rsp_valid == 1'b0, "R1", "rsp_valid in reset", rsp_valid, 0);
        rst_n = 1'b1;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (q.size() != 0 && q[0].due == cyc) begin
                exp_t e;
                e = q.pop_front();
                check(rsp_valid == 1'b1, e.req, "rsp_valid", rsp_valid, 1);
                check(rsp_port == e.port && rsp_virt == e.virt && rsp_id == e.id,
                      e.req, "port/virt/id", {rsp_port, rsp_virt, rsp_id},
                      {e.port, e.virt, e.id});
                check(rsp_addr == e.addr && rsp_write == e.write, e.req, "addr/write",
                      {rsp_write, rsp_addr}, {e.write, e.addr});
            end else if (rsp_valid) begin
                check(1'b0, "R3", "unexpected rsp_valid", 1, 0);
            end
        end
    end

    initial begin
        #400000;
        bad++; total++;
        $display("FAIL watchdog expired act=%0d exp=0", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1 straps both high
        do_reset(1'b1, 1'b1);
        acc(32'h4000_0010, "R1");
        acc(32'h5000_0020, "R1");
        acc(32'h4080_0000, "R8");
        idle(2);
        // R10 edges
        acc(32'h4000_0000, "R10"); acc(32'h40FF_FFFF, "R10");
        acc(32'h3FFF_FFFF, "R10"); acc(32'h4100_0000, "R10");
        acc(32'h5000_0000, "R10"); acc(32'h50FF_FFFF, "R10");
        acc(32'h4FFF_FFFF, "R10"); acc(32'h5100_0000, "R10");
        acc(32'h0000_1000, "R6");
        // R2 same-cycle write turning inner window on
        step(1'b1, 32'h4080_0100, 1'b1, 1'b1, 3'b111, "R2");
        acc(32'h4080_0100, "R7");
        acc(32'h407F_FFFF, "R10"); acc(32'h4090_0000, "R10");
        acc(32'h408F_FFFF, "R7");
        acc(32'h4000_0004, "R4");
        // R2 same-cycle turning AXI off
        step(1'b1, 32'h4000_0008, 1'b0, 1'b1, 3'b110, "R2");
        acc(32'h4000_0008, "R2");
        acc(32'h4080_0000, "R9");
        acc(32'h5000_0000, "R5");
        step(1'b1, 32'h5000_0000, 1'b0, 1'b1, 3'b101, "R2");
        acc(32'h5000_0000, "R6");
        acc(32'h4080_0004, "R7");
        idle(3);
        // R1 straps low, then software enable of AHB
        do_reset(1'b0, 1'b0);
        acc(32'h4000_0000, "R1"); acc(32'h5000_0000, "R1");
        step(1'b1, 32'h5000_0040, 1'b0, 1'b1, 3'b010, "R2");
        acc(32'h5000_0040, "R5");
        acc(32'h4080_0000, "R6");
        // R1 mixed straps
        idle(2);
        do_reset(1'b1, 1'b0);
        acc(32'h4000_0100, "R1"); acc(32'h5000_0100, "R1"); acc(32'h4080_0100, "R1");
        idle(3);
        check(q.size() == 0, "R3", "pending responses", q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule